// File: doc/BRIEF.md
# Byte-wide host control-word port

This block connects an 8-bit host bus to a bank of 32-bit control words that drive the rest of the chip as parallel outputs. The host bus has a 3-bit address, an 8-bit data path in each direction and active-low chip enable, read and write strobes. These strobes are not tied to the block clock.

A control word is never written in place. The host first builds a full 32-bit value in a staging register, one byte per write. It then issues a separate commit write whose data selects the target word. To read a word back, the host loads a readback index and then reads the four bytes of the selected word at four addresses.

Write strobes are brought into the block clock domain through two flops. Each write takes effect once, a few cycles after WR deasserts.

Top module: `cw_host_port`

## Requirements
- R1: A write to address 0, 1, 2 or 3 stores the data byte into staging bits 7:0, 15:8, 23:16 or 31:24, and leaves the other staging bytes as they were.
- R2: A write to address 4 copies the whole staging register into the control word whose index is data bits 4:0. No other control word changes.
- R3: A write to address 5 loads data bits 4:0 into the readback index. After that, a read at address 0, 1, 2 or 3 returns bits 7:0, 15:8, 23:16 or 31:24 of the indexed word.
- R4: While CE or RD is high, the read data is 0x00 and the output enable is low. While both are low, the output enable is high.
- R5: A read at address 5, 6 or 7 returns 0x00.
- R6: A write takes effect only after WR returns high. Holding WR low for any length of time changes no control word.
- R7: A write strobe seen while CE is high has no effect on the staging register, the control words or the readback index.
- R8: After reset, every control word, the staging register and the readback index are zero.
- R9: Writes to address 6 or 7 change no control word, no staging byte and not the readback index.
- R10: A commit does not clear the staging register, so one staged value can be committed to several words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_ce_ni | input | 1 | Chip enable, active low |
| host_rd_ni | input | 1 | Read strobe, active low |
| host_wr_ni | input | 1 | Write strobe, active low; the write acts when this strobe rises |
| host_addr_i | input | 3 | Register address |
| host_data_i | input | 8 | Write data |
| host_data_o | output | 8 | Read data, zero when not being read |
| host_data_oe_o | output | 1 | High while the host is reading |
| ctrl_words_o | output | 32*NUM_WORDS | Control words, word k at bits 32k+31:32k |

## Verification
Staged values are built from a mix of full four-byte sequences and partial rewrites of single bytes. Each staged value is committed to the first index, the last index and a middle index. This separates correct byte-lane steering and index decode from lane swaps or stale staging.

Several kinds of write are interleaved with normal traffic:
- writes with CE high;
- writes to the unused addresses 6 and 7;
- a write that holds WR low for a long time.

These show whether the qualification and edge detection block every spurious action.

Readback is exercised at every byte address and at the unused addresses, with each strobe combination. This tells apart index decode, lane selection and output gating.

// File: rtl/cw_host_port_pkg.sv
package cw_host_port_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned LANES   = WORD_W / BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [ADDR_W-1:0] {
    REG_STG0   = 3'd0,
    REG_STG1   = 3'd1,
    REG_STG2   = 3'd2,
    REG_STG3   = 3'd3,
    REG_COMMIT = 3'd4,
    REG_RDIDX  = 3'd5,
    REG_RSV6   = 3'd6,
    REG_RSV7   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    byte_t             data;
  } host_wr_t;
endpackage

// File: rtl/cw_strobe_sync.sv
module cw_strobe_sync
  import cw_host_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             data_i,
  output logic              commit_o,
  output host_wr_t          wr_o
);
  logic wr_s1, wr_s2, wr_s3;
  logic ce_cap;
  host_wr_t bus_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_s1 <= 1'b1;
      wr_s2 <= 1'b1;
      wr_s3 <= 1'b1;
    end else begin
      wr_s1 <= wr_ni;
      wr_s2 <= wr_s1;
      wr_s3 <= wr_s2;
    end
  end

  // bus sampled while the first sync stage still sees WR low; host holds it past the rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_cap  <= 1'b1;
      bus_cap <= '0;
    end else if (!wr_s1) begin
      ce_cap       <= ce_ni;
      bus_cap.addr <= addr_i;
      bus_cap.data <= data_i;
    end
  end

  assign commit_o = wr_s2 && !wr_s3 && !ce_cap;
  assign wr_o     = bus_cap;
endmodule

// File: rtl/cw_word_file.sv
module cw_word_file
  import cw_host_port_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  host_wr_t               wr_i,
  output word_t [NUM_WORDS-1:0]  words_o,
  output idx_t                   rd_idx_o
);
  word_t                 staging_q;
  word_t [NUM_WORDS-1:0] words_q;
  idx_t                  rd_idx_q;
  idx_t                  wr_idx;

  assign wr_idx = wr_i.data[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staging_q <= '0;
      rd_idx_q  <= '0;
    end else if (commit_i) begin
      unique case (wr_i.addr)
        REG_STG0:  staging_q[0*BYTE_W +: BYTE_W] <= wr_i.data;
        REG_STG1:  staging_q[1*BYTE_W +: BYTE_W] <= wr_i.data;
        REG_STG2:  staging_q[2*BYTE_W +: BYTE_W] <= wr_i.data;
        REG_STG3:  staging_q[3*BYTE_W +: BYTE_W] <= wr_i.data;
        REG_RDIDX: rd_idx_q <= wr_idx;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_q[k] <= '0;
      else if (commit_i && wr_i.addr == REG_COMMIT && int'(wr_idx) == k)
        words_q[k] <= staging_q;
    end
  end

  assign words_o  = words_q;
  assign rd_idx_o = rd_idx_q;
endmodule

// File: rtl/cw_read_mux.sv
module cw_read_mux
  import cw_host_port_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32
) (
  input  logic                  ce_ni,
  input  logic                  rd_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  idx_t                  rd_idx_i,
  input  word_t [NUM_WORDS-1:0] words_i,
  output byte_t                 data_o,
  output logic                  oe_o
);
  word_t sel_word;

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (int'(rd_idx_i) == k) sel_word = words_i[k];
  end

  assign oe_o = !ce_ni && !rd_ni;

  always_comb begin
    data_o = '0;
    if (oe_o) begin
      unique case (addr_i)
        REG_STG0: data_o = sel_word[0*BYTE_W +: BYTE_W];
        REG_STG1: data_o = sel_word[1*BYTE_W +: BYTE_W];
        REG_STG2: data_o = sel_word[2*BYTE_W +: BYTE_W];
        REG_STG3: data_o = sel_word[3*BYTE_W +: BYTE_W];
        default:  data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cw_host_port.sv
module cw_host_port
  import cw_host_port_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        host_ce_ni,
  input  logic                        host_rd_ni,
  input  logic                        host_wr_ni,
  input  logic [2:0]                  host_addr_i,
  input  logic [7:0]                  host_data_i,
  output logic [7:0]                  host_data_o,
  output logic                        host_data_oe_o,
  output logic [32*NUM_WORDS-1:0]     ctrl_words_o
);
  logic                  commit;
  host_wr_t              wr_bus;
  word_t [NUM_WORDS-1:0] words;
  idx_t                  rd_idx;

  cw_strobe_sync i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (host_ce_ni),
    .wr_ni    (host_wr_ni),
    .addr_i   (host_addr_i),
    .data_i   (host_data_i),
    .commit_o (commit),
    .wr_o     (wr_bus)
  );

  cw_word_file #(.NUM_WORDS(NUM_WORDS)) i_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .wr_i     (wr_bus),
    .words_o  (words),
    .rd_idx_o (rd_idx)
  );

  cw_read_mux #(.NUM_WORDS(NUM_WORDS)) i_rmux (
    .ce_ni    (host_ce_ni),
    .rd_ni    (host_rd_ni),
    .addr_i   (host_addr_i),
    .rd_idx_i (rd_idx),
    .words_i  (words),
    .data_o   (host_data_o),
    .oe_o     (host_data_oe_o)
  );

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_flat
    assign ctrl_words_o[k*WORD_W +: WORD_W] = words[k];
  end
endmodule

// File: rtl/cw_host_port_chk.sv
module cw_host_port_chk #(
  parameter int unsigned NUM_WORDS = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    host_ce_ni,
  input logic                    host_rd_ni,
  input logic [2:0]              host_addr_i,
  input logic [7:0]              host_data_o,
  input logic                    host_data_oe_o,
  input logic [32*NUM_WORDS-1:0] ctrl_words_o,
  input logic                    commit
);
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_ce_ni || host_rd_ni) |-> (host_data_o == 8'h00 && !host_data_oe_o));

  a_r4_read_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_ce_ni && !host_rd_ni) |-> host_data_oe_o);

  a_r5_unused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i >= 3'd5) |-> host_data_o == 8'h00);

  a_r6_change_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_words_o) |-> $past(commit));

  a_r6_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !commit);

  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> ctrl_words_o == '0);
endmodule

bind cw_host_port cw_host_port_chk #(.NUM_WORDS(NUM_WORDS)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_ce_ni     (host_ce_ni),
  .host_rd_ni     (host_rd_ni),
  .host_addr_i    (host_addr_i),
  .host_data_o    (host_data_o),
  .host_data_oe_o (host_data_oe_o),
  .ctrl_words_o   (ctrl_words_o),
  .commit         (commit)
);

// File: tb/test_cw_host_port.sv
module test_cw_host_port;
  localparam int NW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic oe;
  logic [32*NW-1:0] words;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;
  logic [31:0] m_stage = '0;
  logic [31:0] m_words [NW];
  int m_idx = 0;

  always #4 clk = ~clk;

  cw_host_port #(.NUM_WORDS(NW)) i_cw_host_port (
    .clk_i(clk), .rst_ni(rst_n), .host_ce_ni(ce_n), .host_rd_ni(rd_n),
    .host_wr_ni(wr_n), .host_addr_i(addr), .host_data_i(din),
    .host_data_o(dout), .host_data_oe_o(oe), .ctrl_words_o(words));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R6: nothing moves while WR is still low)
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int k = 0; k < NW; k++) begin
        if (words[k*32 +: 32] !== m_words[k]) begin
          checks++; errors++;
          $display("FAIL R6 word%0d actual=%h expected=%h", k, words[k*32 +: 32], m_words[k]);
        end
      end
    end
  end

  task automatic host_write(logic [2:0] a, logic [7:0] d, bit ce_on, int low_cyc);
    @(negedge clk);
    addr = a; din = d; ce_n = !ce_on;
    @(negedge clk); wr_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    cmp_en = 1'b0;
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    if (ce_on) begin
      case (a)
        3'd0, 3'd1, 3'd2, 3'd3: m_stage[a*8 +: 8] = d;
        3'd4: m_words[d[4:0]] = m_stage;
        3'd5: m_idx = d[4:0];
        default: ;
      endcase
    end
    cmp_en = 1'b1;
  endtask

  task automatic host_read(logic [2:0] a, bit ce_on, bit rd_on, output logic [7:0] d, output logic o);
    @(negedge clk);
    addr = a; ce_n = !ce_on; rd_n = !rd_on;
    #1;
    d = dout; o = oe;
    @(negedge clk);
    ce_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic stage_word(logic [31:0] v);
    for (int b = 0; b < 4; b++) host_write(3'(b), v[b*8 +: 8], 1'b1, 3);
  endtask

  task automatic read_word(string req, int idx);
    logic [7:0] d; logic o;
    host_write(3'd5, 8'(idx), 1'b1, 3);
    for (int b = 0; b < 4; b++) begin
      host_read(3'(b), 1'b1, 1'b1, d, o);
      check(req, {24'h0, d}, {24'h0, m_words[m_idx][b*8 +: 8]});
    end
  endtask

  initial begin
    logic [7:0] d; logic o;
    logic [31:0] lfsr;
    for (int k = 0; k < NW; k++) m_words[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    for (int k = 0; k < NW; k += 10) check("R8 word", words[k*32 +: 32], 32'h0);
    read_word("R8 readback", 0);
    cmp_en = 1'b1;

    // R1 R2: low byte 0x24 into word 0
    host_write(3'd0, 8'h24, 1'b1, 3);
    host_write(3'd4, 8'h00, 1'b1, 3);
    check("R2 word0", words[31:0], 32'h0000_0024);

    // R1 full value, R10 commit to several words
    stage_word(32'hC0DE_5A17);
    host_write(3'd4, 8'd31, 1'b1, 3);
    host_write(3'd4, 8'd7, 1'b1, 3);
    check("R10 word31", words[31*32 +: 32], 32'hC0DE_5A17);
    check("R10 word7", words[7*32 +: 32], 32'hC0DE_5A17);

    // R1 single lane rewrite
    host_write(3'd2, 8'h99, 1'b1, 3);
    host_write(3'd4, 8'd12, 1'b1, 3);
    check("R1 lane2", words[12*32 +: 32], 32'hC099_5A17);

    // R7 CE high: ignored on every register
    host_write(3'd4, 8'd3, 1'b0, 3);
    host_write(3'd0, 8'hFF, 1'b0, 3);
    host_write(3'd5, 8'd7, 1'b0, 3);
    check("R7 word3", words[3*32 +: 32], 32'h0);
    host_read(3'd0, 1'b1, 1'b1, d, o);
    check("R7 rdidx", {24'h0, d}, 32'h0000_0024);
    host_write(3'd4, 8'd3, 1'b1, 3);
    check("R7 staging", words[3*32 +: 32], 32'hC099_5A17);

    // R9 writes to 6 and 7 ignored
    host_write(3'd6, 8'h12, 1'b1, 3);
    host_write(3'd7, 8'h01, 1'b1, 3);
    host_read(3'd0, 1'b1, 1'b1, d, o);
    check("R9 rdidx", {24'h0, d}, 32'h0000_0024);
    host_write(3'd4, 8'd20, 1'b1, 3);
    check("R9 staging", words[20*32 +: 32], 32'hC099_5A17);

    // R6 long WR low: monitor compares every clock during the hold
    stage_word(32'h0BAD_F00D);
    host_write(3'd4, 8'd0, 1'b1, 40);
    check("R6 word0", words[31:0], 32'h0BAD_F00D);

    // R3 readback
    read_word("R3 idx7", 7);
    read_word("R3 idx0", 0);
    read_word("R3 idx31", 31);

    // R5 unused read addresses
    for (int a = 5; a < 8; a++) begin
      host_read(3'(a), 1'b1, 1'b1, d, o);
      check("R5 data", {24'h0, d}, 32'h0);
      check("R4 oe on", {31'h0, o}, 32'h1);
    end

    // R4 gating
    host_read(3'd0, 1'b1, 1'b0, d, o);
    check("R4 rd high data", {24'h0, d}, 32'h0);
    check("R4 rd high oe", {31'h0, o}, 32'h0);
    host_read(3'd0, 1'b0, 1'b1, d, o);
    check("R4 ce high data", {24'h0, d}, 32'h0);
    check("R4 ce high oe", {31'h0, o}, 32'h0);

    // mixed traffic
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 12; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (n % 3 == 0) stage_word(lfsr);
      else host_write(3'(n % 4), lfsr[15:8], 1'b1, 2);
      host_write(3'd4, {3'b0, lfsr[20:16]}, 1'b1, 3);
      read_word("R2 R3 mixed", int'(lfsr[20:16]));
    end

    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule